// File: doc/BRIEF.md
# Status-Flag Branch Condition Unit

This unit resolves a conditional relative branch. Each request supplies an 8-bit status word, a condition, a signed 7-bit word offset and the address of the branch itself. One clock later the unit returns whether the branch is taken, the address to fetch next and how many cycles the branch costs (one if it falls through, two if it is taken).

A condition can be given in either of two forms. The generic form names one status bit by index and the value that bit must have. The alias form is a 4-bit code for a named test: equal, not equal, unsigned lower, unsigned same-or-higher, signed less-than, signed greater-or-equal, and set or clear tests on single flags. The two signed tests compare N against V directly, so they do not depend on the stored sign bit S. A caller that needs greater-than or less-or-equal swaps the operands of the compare that sets the flags, then uses less-than or greater-or-equal. The unit has no separate codes for those two cases.

Top module: `flagbr_unit`

## Requirements
- R1: `resp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low in the cycle after each cycle in which `req_valid` is low. The results of a request appear in that same following cycle.
- R2: With `use_alias` = 0, `taken` is 1 exactly when `status[gen_idx]` equals `gen_pol`. The status bit positions are: C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R3: With `use_alias` = 1, code 4 (signed less-than) is taken when N xor V = 1, and code 5 (signed greater-or-equal) is taken when N xor V = 0. Both use the N and V bits and ignore the value of S.
- R4: The other alias codes are: 0 Z=1, 1 Z=0, 2 C=1 (unsigned lower), 3 C=0 (unsigned same-or-higher), 6 N=1, 7 N=0, 8 V=1, 9 V=0, 10 H=1, 11 H=0, 12 T=1, 13 T=0, 14 I=1, 15 I=0. Each code is taken when the named flag has the stated value.
- R5: When taken, `next_pc` = `cur_pc` + sign-extended `offset` + 1, modulo 2^PCW. This holds at both offset limits, -64 and +63.
- R6: When not taken, `next_pc` = `cur_pc` + 1, modulo 2^PCW.
- R7: `cycles` is 2 for a taken branch and 1 for a branch that is not taken.
- R8: In a cycle with `req_valid` low, `taken`, `next_pc` and `cycles` keep their values, even if the other inputs change.
- R9: While `rst` is high, `resp_valid`, `taken`, `next_pc` and `cycles` are all 0 after each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A branch request is present this cycle |
| status | input | 8 | Status flags: C0 Z1 N2 V3 S4 H5 T6 I7 |
| use_alias | input | 1 | 1 selects the alias code, 0 selects the generic index and polarity |
| alias_code | input | 4 | Named test code, see R3 and R4 |
| gen_idx | input | 3 | Generic form: index of the status bit to test |
| gen_pol | input | 1 | Generic form: the value the bit must have for the branch to be taken |
| offset | input | OFFW (7) | Signed word offset k |
| cur_pc | input | PCW (16) | Address of the branch |
| resp_valid | output | 1 | Result is valid |
| taken | output | 1 | The branch is taken |
| next_pc | output | PCW (16) | Next fetch address |
| cycles | output | 2 | Cycle cost: 1 or 2 |

## Verification
The assertions assume that `rst` is high for at least one edge before any request, and that inputs change only between edges, so that `$past` sees the value that was registered. They also assume PCW is larger than OFFW, which makes sign extension meaningful. The stimulus meets these assumptions: inputs are driven on the falling edge, reset is held for several cycles first, and every request lasts exactly one cycle. Hold cycles with scrambled inputs are placed between requests so that R8 is exercised.

// File: rtl/flagbr_pkg.sv
package flagbr_pkg;
  // Bit positions inside the status word. The decoder depends on them.
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  localparam int STW  = 8;
  localparam int IDXW = $clog2(STW);
  localparam int CODW = 4;
  localparam int CYCW = 2;

  typedef logic [IDXW-1:0] flag_idx_t;

  // Group of an alias code, taken from code[3:1]. Code bit 0 gives the polarity.
  typedef enum logic [2:0] {
    GRP_ZERO  = 3'd0,
    GRP_CARRY = 3'd1,
    GRP_SLESS = 3'd2,
    GRP_NEG   = 3'd3,
    GRP_OVF   = 3'd4,
    GRP_HALF  = 3'd5,
    GRP_TBIT  = 3'd6,
    GRP_INT   = 3'd7
  } alias_grp_e;

  localparam logic [CYCW-1:0] CYC_FALL = 2'd1;
  localparam logic [CYCW-1:0] CYC_JUMP = 2'd2;
endpackage

// File: rtl/flagbr_alias_dec.sv
module flagbr_alias_dec
  import flagbr_pkg::*;
(
  input  logic [CODW-1:0] code,
  output flag_idx_t       idx,
  output logic            want_set,
  output logic            signed_rel
);
  alias_grp_e grp;

  assign grp      = alias_grp_e'(code[CODW-1:1]);
  assign want_set = ~code[0];

  always_comb begin
    signed_rel = 1'b0;
    idx        = flag_idx_t'(FL_Z);
    unique case (grp)
      GRP_ZERO:  idx = flag_idx_t'(FL_Z);
      GRP_CARRY: idx = flag_idx_t'(FL_C);
      GRP_SLESS: begin
        idx        = flag_idx_t'(FL_S);
        signed_rel = 1'b1;
      end
      GRP_NEG:   idx = flag_idx_t'(FL_N);
      GRP_OVF:   idx = flag_idx_t'(FL_V);
      GRP_HALF:  idx = flag_idx_t'(FL_H);
      GRP_TBIT:  idx = flag_idx_t'(FL_T);
      GRP_INT:   idx = flag_idx_t'(FL_I);
      default:   idx = flag_idx_t'(FL_Z);
    endcase
  end
endmodule

// File: rtl/flagbr_cond_eval.sv
module flagbr_cond_eval
  import flagbr_pkg::*;
(
  input  logic [STW-1:0]  status,
  input  logic            use_alias,
  input  logic [CODW-1:0] alias_code,
  input  flag_idx_t       gen_idx,
  input  logic            gen_pol,
  output logic            cond_true
);
  flag_idx_t a_idx;
  logic      a_pol;
  logic      a_signed;
  flag_idx_t pick_idx;
  logic      pick_pol;
  logic      test_bit;

  flagbr_alias_dec u_dec (
    .code       (alias_code),
    .idx        (a_idx),
    .want_set   (a_pol),
    .signed_rel (a_signed)
  );

  assign pick_idx = use_alias ? a_idx : gen_idx;
  assign pick_pol = use_alias ? a_pol : gen_pol;

  // For the signed tests, N xor V is formed here and the stored S bit is not used.
  always_comb begin
    if (use_alias && a_signed)
      test_bit = status[FL_N] ^ status[FL_V];
    else
      test_bit = status[pick_idx];
  end

  assign cond_true = (test_bit == pick_pol);
endmodule

// File: rtl/flagbr_target.sv
module flagbr_target #(
  parameter int PCW  = 16,
  parameter int OFFW = 7
) (
  input  logic [PCW-1:0]  cur_pc,
  input  logic [OFFW-1:0] offset,
  output logic [PCW-1:0]  seq_pc,
  output logic [PCW-1:0]  jump_pc
);
  localparam int EXTW = PCW - OFFW;

  logic [PCW-1:0] off_ext;

  generate
    if (EXTW > 0) begin : g_ext
      assign off_ext = {{EXTW{offset[OFFW-1]}}, offset};
    end else begin : g_trunc
      assign off_ext = offset[PCW-1:0];
    end
  endgenerate

  assign seq_pc  = cur_pc + PCW'(1);
  assign jump_pc = seq_pc + off_ext;
endmodule

// File: rtl/flagbr_unit.sv
module flagbr_unit
  import flagbr_pkg::*;
#(
  parameter int PCW  = 16,
  parameter int OFFW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [7:0]      status,
  input  logic            use_alias,
  input  logic [3:0]      alias_code,
  input  logic [2:0]      gen_idx,
  input  logic            gen_pol,
  input  logic [OFFW-1:0] offset,
  input  logic [PCW-1:0]  cur_pc,
  output logic            resp_valid,
  output logic            taken,
  output logic [PCW-1:0]  next_pc,
  output logic [1:0]      cycles
);
  logic           cond_true;
  logic [PCW-1:0] seq_pc;
  logic [PCW-1:0] jump_pc;

  flagbr_cond_eval u_eval (
    .status     (status),
    .use_alias  (use_alias),
    .alias_code (alias_code),
    .gen_idx    (gen_idx),
    .gen_pol    (gen_pol),
    .cond_true  (cond_true)
  );

  flagbr_target #(.PCW(PCW), .OFFW(OFFW)) u_tgt (
    .cur_pc  (cur_pc),
    .offset  (offset),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      taken      <= 1'b0;
      next_pc    <= '0;
      cycles     <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        taken   <= cond_true;
        next_pc <= cond_true ? jump_pc : seq_pc;
        cycles  <= cond_true ? CYC_JUMP : CYC_FALL;
      end
    end
  end
endmodule

// File: rtl/flagbr_chk.sv
module flagbr_chk #(
  parameter int PCW  = 16,
  parameter int OFFW = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [7:0]      status,
  input logic            use_alias,
  input logic [3:0]      alias_code,
  input logic [2:0]      gen_idx,
  input logic            gen_pol,
  input logic [OFFW-1:0] offset,
  input logic [PCW-1:0]  cur_pc,
  input logic            resp_valid,
  input logic            taken,
  input logic [PCW-1:0]  next_pc,
  input logic [1:0]      cycles
);
  logic [PCW-1:0] k_ext;
  logic           gen_hit;
  logic           nv_rel;

  assign k_ext   = {{(PCW-OFFW){offset[OFFW-1]}}, offset};
  assign gen_hit = (status[gen_idx] == gen_pol);
  assign nv_rel  = status[2] ^ status[3];

  AST_RESP_RISES: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid); // R1
  AST_RESP_FALLS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid); // R1
  AST_GENERIC_MATCH: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !use_alias) |=> (taken == $past(gen_hit))); // R2
  AST_SIGNED_LESS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && use_alias && alias_code == 4'd4) |=> (taken == $past(nv_rel))); // R3
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!taken || next_pc == $past(cur_pc) + $past(k_ext) + PCW'(1))); // R5
  AST_FALL_TARGET: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (taken || next_pc == $past(cur_pc) + PCW'(1))); // R6
  AST_CYCLE_COST: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (cycles == (taken ? 2'd2 : 2'd1))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(taken) && $stable(next_pc) && $stable(cycles))); // R8
endmodule

bind flagbr_unit flagbr_chk #(.PCW(PCW), .OFFW(OFFW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .status     (status),
  .use_alias  (use_alias),
  .alias_code (alias_code),
  .gen_idx    (gen_idx),
  .gen_pol    (gen_pol),
  .offset     (offset),
  .cur_pc     (cur_pc),
  .resp_valid (resp_valid),
  .taken      (taken),
  .next_pc    (next_pc),
  .cycles     (cycles)
);

// File: tb/flagbr_unit_test.sv
`timescale 1ns/1ps
module flagbr_unit_test;
  localparam int PCW  = 16;
  localparam int OFFW = 7;
  localparam int NVEC = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [7:0]      status = '0;
  logic            use_alias = 1'b0;
  logic [3:0]      alias_code = '0;
  logic [2:0]      gen_idx = '0;
  logic            gen_pol = 1'b0;
  logic [OFFW-1:0] offset = '0;
  logic [PCW-1:0]  cur_pc = '0;
  logic            resp_valid;
  logic            taken;
  logic [PCW-1:0]  next_pc;
  logic [1:0]      cycles;

  int n_run = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  flagbr_unit #(.PCW(PCW), .OFFW(OFFW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .status(status),
    .use_alias(use_alias), .alias_code(alias_code), .gen_idx(gen_idx),
    .gen_pol(gen_pol), .offset(offset), .cur_pc(cur_pc),
    .resp_valid(resp_valid), .taken(taken), .next_pc(next_pc), .cycles(cycles)
  );

  // Fields: alias[37] sel[36:33] pol[32] status[31:24] off[23:17] pc[16:1] exp_taken[0]
  localparam logic [37:0] VEC [NVEC] = '{
    {1'b1, 4'd4,  1'b0, 8'h08, 7'h40, 16'h0100, 1'b1},  // R3 LT, V only, S clear
    {1'b1, 4'd4,  1'b0, 8'h1C, 7'h05, 16'h0200, 1'b0},  // R3 LT, N=V
    {1'b1, 4'd5,  1'b0, 8'h10, 7'h3F, 16'h0000, 1'b1},  // R3 GE, S set but N=V=0
    {1'b1, 4'd0,  1'b0, 8'h02, 7'h00, 16'h1234, 1'b1},  // R4 EQ
    {1'b1, 4'd1,  1'b0, 8'h02, 7'h00, 16'h1234, 1'b0},  // R4 NE
    {1'b1, 4'd2,  1'b0, 8'h01, 7'h7F, 16'h0010, 1'b1},  // R4 LO
    {1'b1, 4'd3,  1'b0, 8'h01, 7'h11, 16'h0010, 1'b0},  // R4 SH
    {1'b1, 4'd15, 1'b0, 8'h80, 7'h02, 16'hFFFF, 1'b0},  // R4 ID
    {1'b1, 4'd14, 1'b0, 8'h80, 7'h02, 16'hFFFF, 1'b1},  // R4 IE, wraps
    {1'b0, 4'd4,  1'b1, 8'h10, 7'h3F, 16'hFFC0, 1'b1},  // R2 generic S bit
    {1'b1, 4'd13, 1'b0, 8'h00, 7'h40, 16'h0020, 1'b1},  // R4 TC, wraps low
    {1'b1, 4'd10, 1'b0, 8'h20, 7'h01, 16'h7FFF, 1'b1}   // R4 HS
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic ref_take(input logic al, input logic [3:0] sel,
                                    input logic pol, input logic [7:0] st);
    logic c, z, n, v, h, t, i;
    c = st[0]; z = st[1]; n = st[2]; v = st[3]; h = st[5]; t = st[6]; i = st[7];
    if (!al) return st[sel[2:0]] == pol;
    case (sel)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n != v;
      4'd5:  return n == v;
      4'd6:  return n;
      4'd7:  return !n;
      4'd8:  return v;
      4'd9:  return !v;
      4'd10: return h;
      4'd11: return !h;
      4'd12: return t;
      4'd13: return !t;
      4'd14: return i;
      default: return !i;
    endcase
  endfunction

  function automatic logic [PCW-1:0] ref_pc(input logic tk, input logic [OFFW-1:0] k,
                                            input logic [PCW-1:0] pc);
    int sk;
    sk = k[OFFW-1] ? int'(k) - (1 << OFFW) : int'(k);
    return tk ? PCW'(int'(pc) + sk + 1) : PCW'(int'(pc) + 1);
  endfunction

  // Drive on a falling edge, sample on the next falling edge (one register stage).
  task automatic run_req(input logic al, input logic [3:0] sel, input logic pol,
                         input logic [7:0] st, input logic [OFFW-1:0] k,
                         input logic [PCW-1:0] pc, input logic exp_tk, input string tag);
    @(negedge clk);
    req_valid = 1'b1; use_alias = al; alias_code = sel; gen_idx = sel[2:0];
    gen_pol = pol; status = st; offset = k; cur_pc = pc;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R1 valid"}, 32'(resp_valid), 32'd1);
    check({tag, " taken"}, 32'(taken), 32'(exp_tk));
    check({tag, exp_tk ? " R5 target" : " R6 target"}, 32'(next_pc), 32'(ref_pc(exp_tk, k, pc)));
    check({tag, " R7 cycles"}, 32'(cycles), exp_tk ? 32'd2 : 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [PCW-1:0] hold_pc;
    logic           hold_tk;
    logic [1:0]     hold_cy;

    // R9: reset clears everything, even with a request present
    req_valid = 1'b1; status = 8'hFF;
    repeat (3) @(negedge clk);
    check("R9 resp_valid", 32'(resp_valid), 32'd0);
    check("R9 taken", 32'(taken), 32'd0);
    check("R9 next_pc", 32'(next_pc), 32'd0);
    check("R9 cycles", 32'(cycles), 32'd0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", 32'(resp_valid), 32'd0);

    for (int e = 0; e < NVEC; e++)
      run_req(VEC[e][37], VEC[e][36:33], VEC[e][32], VEC[e][31:24],
              VEC[e][23:17], VEC[e][16:1], VEC[e][0], "table R3/R4/R2");

    // R2: every index and polarity against the model
    for (int idx = 0; idx < 8; idx++)
      for (int pol = 0; pol < 2; pol++)
        for (int p = 0; p < 4; p++) begin
          logic [7:0] st;
          st = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'h01 << idx : 8'hA5;
          run_req(1'b0, 4'(idx), 1'(pol), st, (pol != 0) ? 7'h40 : 7'h3F,
                  16'h4000 + 16'(idx), ref_take(1'b0, 4'(idx), 1'(pol), st), "R2 generic");
        end

    // R3/R4: every alias code over several status words
    for (int code = 0; code < 16; code++)
      for (int p = 0; p < 4; p++) begin
        logic [7:0] st;
        st = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'h5A : 8'h14;
        run_req(1'b1, 4'(code), 1'b0, st, 7'(code * 5), 16'h8000 + 16'(code),
                ref_take(1'b1, 4'(code), 1'b0, st), "R4 alias");
      end

    // R8: outputs hold while idle and the inputs change
    run_req(1'b1, 4'd0, 1'b0, 8'h02, 7'h40, 16'h0100, 1'b1, "R8 setup");
    hold_pc = next_pc; hold_tk = taken; hold_cy = cycles;
    status = 8'h00; cur_pc = 16'hDEAD; offset = 7'h3F; alias_code = 4'd1;
    repeat (3) @(negedge clk);
    check("R8 resp_valid low", 32'(resp_valid), 32'd0);
    check("R8 next_pc held", 32'(next_pc), 32'(hold_pc));
    check("R8 taken held", 32'(taken), 32'(hold_tk));
    check("R8 cycles held", 32'(cycles), 32'(hold_cy));

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule